// File: doc/BRIEF.md
# Hardware Fault Cause Classifier

This block sits at the entry of the fault trap. On a strobe it captures the machine's error flags. These are the four primary error flags, the four memory-pipe stage flags, the bus parity and address-range flags, two configuration enables, the current and pipe task numbers, the reference's dirty indication and its virtual page. From that snapshot it decides what the trap handler does next. There are three outcomes: stop the machine with a maintenance-panel crash code, resume the interrupted task, or notify the emulator with a 16-bit signed trap parameter.

The decision follows a fixed priority. A memory error reported on its own is handled first, because it is time critical. A run without any primary flag is taken as a breakpoint. Parity errors in the control store or register file always stop the machine. A stack overflow either traps or stops, depending on the notify enable. On the memory path, the bus parity and address-range flags are checked before the pipe-stage flags, and second-stage flags win over first-stage flags.

Top module: `fault_classifier`

## Requirements
- R1: After reset, done_o is 0 and action_o, code_o and parm_o are 0. A strobe on vld_i in one cycle makes done_o 1 in the next cycle, with the verdict present on the outputs. Without a strobe, done_o is 0 and the outputs keep their last value.
- R2: action_o is one-hot: bit 0 means crash, bit 1 means resume, bit 2 means notify. A crash gives parm_o = 0. A notify gives code_o = 0. A resume gives both as 0.
- R3: The memory path is taken when mem_err_i is the only primary flag set. When no primary flag is set, the verdict is a crash with code 8'h10 + cur_task_i (breakpoint).
- R4: If cstore_par_i or rfile_par_i is set, the verdict is a crash with code 8'h20 + F. F is the 4-bit value {stk_ovf_i, cstore_par_i, rfile_par_i, mem_err_i}, with stk_ovf_i as the most significant bit.
- R5: A stack overflow with no parity flag gives a notify with parm 16'h4000 when notify_en_i is 1. Otherwise it gives a crash with code 8'h30.
- R6: On the memory path, bus_par_i takes precedence over every other memory flag. With bus_crash_en_i at 0, the fault is ignored and the verdict is resume. Otherwise it is a crash with code 8'h40 + cur_task_i.
- R7: On the memory path without bus parity, addr_oob_i gives a notify with parm 16'hFFFF when notify_en_i is 1. Otherwise it gives a crash with code 8'h50 + cur_task_i.
- R8: Next, if both second-stage flags are set, the verdict is a crash with code 8'h80. If exactly one is set, the verdict is a crash with code 8'h70 + pipe_task_i. In both cases the first-stage flags are ignored.
- R9: Next, a first-stage flag (either one) gives a notify only when notify_en_i is 1 and pipe_task_i is 0. Otherwise it gives a crash with code 8'h60 + pipe_task_i.
- R10: The first-stage notify parameter is {2'b00, vpage_i} (page fault) when dirty_i is 0, and {2'b10, vpage_i} (write protect) when dirty_i is 1. Because of this, page 14'h3FFF never yields 16'hFFFF.
- R11: On the memory path with no memory flag set at all, the verdict is a crash with code 8'h81.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vld_i | input | 1 | Snapshot strobe |
| stk_ovf_i | input | 1 | Stack overflow flag |
| cstore_par_i | input | 1 | Control-store parity flag |
| rfile_par_i | input | 1 | Register-file parity flag |
| mem_err_i | input | 1 | Memory error summary flag |
| st2a_err_i | input | 1 | Second-stage error, pipe A |
| st2b_err_i | input | 1 | Second-stage error, pipe B |
| st1a_err_i | input | 1 | First-stage error, pipe A |
| st1b_err_i | input | 1 | First-stage error, pipe B |
| bus_par_i | input | 1 | Bus parity flag |
| addr_oob_i | input | 1 | Address out of bounds flag |
| notify_en_i | input | 1 | Configuration: trap to emulator instead of crashing |
| bus_crash_en_i | input | 1 | Configuration: crash on bus parity instead of ignoring it |
| cur_task_i | input | 4 | Task running at fault entry |
| pipe_task_i | input | 4 | Task that issued the faulting reference |
| dirty_i | input | 1 | Dirty indication of the reference's map entry |
| vpage_i | input | 14 | Virtual page of the reference |
| done_o | output | 1 | Verdict valid, one cycle after the strobe |
| action_o | output | 3 | One-hot action: crash, resume, notify |
| code_o | output | 8 | Crash code |
| parm_o | output | 16 | Trap parameter |

## Verification
Random snapshots are weighted toward the memory-only path, so that combinations of bus parity, range, second-stage and first-stage flags contest priority together. This separates an ordering mistake from a wrong code. Directed cases vary one selector at a time against a fixed flag set: the notify enable, the bus-crash enable, pipe task zero versus nonzero, and the dirty bit. Each of these flips a single verdict. Page 14'h3FFF is driven under both dirty values, which tells the write-protect parameter apart from the out-of-bounds value. Every parity combination is driven, which exposes a wrong bit order in the parity crash code.

// File: rtl/fc_pkg.sv
`timescale 1ns/1ps
package fc_pkg;
  localparam int TASK_W = 4;
  localparam int PAGE_W = 14;
  localparam int PARM_W = PAGE_W + 2;
  localparam int CODE_W = 8;

  typedef enum logic [2:0] {
    ACT_IDLE   = 3'b000,
    ACT_CRASH  = 3'b001,
    ACT_RESUME = 3'b010,
    ACT_NOTIFY = 3'b100
  } act_e;

  localparam logic [CODE_W-1:0] CC_BREAK  = 8'h10;
  localparam logic [CODE_W-1:0] CC_PARITY = 8'h20;
  localparam logic [CODE_W-1:0] CC_STACK  = 8'h30;
  localparam logic [CODE_W-1:0] CC_BUSPAR = 8'h40;
  localparam logic [CODE_W-1:0] CC_RANGE  = 8'h50;
  localparam logic [CODE_W-1:0] CC_STG1   = 8'h60;
  localparam logic [CODE_W-1:0] CC_STG2   = 8'h70;
  localparam logic [CODE_W-1:0] CC_DOUBLE = 8'h80;
  localparam logic [CODE_W-1:0] CC_NOMEM  = 8'h81;

  localparam logic [PARM_W-1:0] PARM_RANGE = '1;
  localparam logic [PARM_W-1:0] PARM_STACK = PARM_W'(1) << PAGE_W;

  typedef struct packed {
    act_e                act;
    logic [CODE_W-1:0]   code;
    logic [PARM_W-1:0]   parm;
  } verdict_t;

  function automatic verdict_t v_crash(input logic [CODE_W-1:0] c);
    verdict_t v;
    v.act  = ACT_CRASH;
    v.code = c;
    v.parm = '0;
    return v;
  endfunction

  function automatic verdict_t v_notify(input logic [PARM_W-1:0] p);
    verdict_t v;
    v.act  = ACT_NOTIFY;
    v.code = '0;
    v.parm = p;
    return v;
  endfunction

  function automatic logic [CODE_W-1:0] task_code(input logic [CODE_W-1:0] base,
                                                  input logic [TASK_W-1:0] t);
    return base + CODE_W'(t);
  endfunction

  // page fault keeps the top two bits at 00, write protect at 10
  function automatic logic [PARM_W-1:0] page_parm(input logic dirty,
                                                  input logic [PAGE_W-1:0] pg);
    return {dirty, 1'b0, pg};
  endfunction
endpackage

// File: rtl/fc_primary.sv
`timescale 1ns/1ps
module fc_primary
  import fc_pkg::*;
(
  input  logic              stk_ovf,
  input  logic              cstore_par,
  input  logic              rfile_par,
  input  logic              mem_err,
  input  logic              notify_en,
  input  logic [TASK_W-1:0] cur_task,
  output logic              mem_only,
  output verdict_t          verdict
);
  logic [3:0] field;
  logic       any_par;

  assign field    = {stk_ovf, cstore_par, rfile_par, mem_err};
  assign any_par  = cstore_par | rfile_par;
  assign mem_only = (field == 4'b0001);

  always_comb begin
    verdict = '0;
    if (field == 4'b0000)
      verdict = v_crash(task_code(CC_BREAK, cur_task));
    else if (any_par)
      verdict = v_crash(CC_PARITY + CODE_W'(field));
    else if (stk_ovf)
      verdict = notify_en ? v_notify(PARM_STACK) : v_crash(CC_STACK);
  end
endmodule

// File: rtl/fc_mempath.sv
`timescale 1ns/1ps
module fc_mempath
  import fc_pkg::*;
(
  input  logic              bus_par,
  input  logic              addr_oob,
  input  logic              st2a,
  input  logic              st2b,
  input  logic              st1a,
  input  logic              st1b,
  input  logic              notify_en,
  input  logic              bus_crash_en,
  input  logic [TASK_W-1:0] cur_task,
  input  logic [TASK_W-1:0] pipe_task,
  input  logic              dirty,
  input  logic [PAGE_W-1:0] vpage,
  output verdict_t          verdict
);
  logic [3:0] stg_idx;
  logic       emu_ref;

  assign stg_idx = {st2a, st2b, st1a, st1b};
  assign emu_ref = (pipe_task == '0);

  always_comb begin
    verdict = '0;
    if (bus_par) begin
      if (bus_crash_en) verdict = v_crash(task_code(CC_BUSPAR, cur_task));
      else              verdict.act = ACT_RESUME;
    end else if (addr_oob) begin
      verdict = notify_en ? v_notify(PARM_RANGE)
                          : v_crash(task_code(CC_RANGE, cur_task));
    end else begin
      casez (stg_idx)
        4'b11??: verdict = v_crash(CC_DOUBLE);
        4'b10??,
        4'b01??: verdict = v_crash(task_code(CC_STG2, pipe_task));
        4'b001?,
        4'b0001: verdict = (notify_en && emu_ref) ? v_notify(page_parm(dirty, vpage))
                                                  : v_crash(task_code(CC_STG1, pipe_task));
        default: verdict = v_crash(CC_NOMEM);
      endcase
    end
  end
endmodule

// File: rtl/fault_classifier.sv
`timescale 1ns/1ps
module fault_classifier
  import fc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic              stk_ovf_i,
  input  logic              cstore_par_i,
  input  logic              rfile_par_i,
  input  logic              mem_err_i,
  input  logic              st2a_err_i,
  input  logic              st2b_err_i,
  input  logic              st1a_err_i,
  input  logic              st1b_err_i,
  input  logic              bus_par_i,
  input  logic              addr_oob_i,
  input  logic              notify_en_i,
  input  logic              bus_crash_en_i,
  input  logic [TASK_W-1:0] cur_task_i,
  input  logic [TASK_W-1:0] pipe_task_i,
  input  logic              dirty_i,
  input  logic [PAGE_W-1:0] vpage_i,
  output logic              done_o,
  output logic [2:0]        action_o,
  output logic [CODE_W-1:0] code_o,
  output logic [PARM_W-1:0] parm_o
);
  // named internal events, observed by the checker
  logic     mem_only_w;
  verdict_t pri_v, mem_v, sel_v, q_v;

  fc_primary u_pri (
    .stk_ovf    (stk_ovf_i),
    .cstore_par (cstore_par_i),
    .rfile_par  (rfile_par_i),
    .mem_err    (mem_err_i),
    .notify_en  (notify_en_i),
    .cur_task   (cur_task_i),
    .mem_only   (mem_only_w),
    .verdict    (pri_v)
  );

  fc_mempath u_mem (
    .bus_par      (bus_par_i),
    .addr_oob     (addr_oob_i),
    .st2a         (st2a_err_i),
    .st2b         (st2b_err_i),
    .st1a         (st1a_err_i),
    .st1b         (st1b_err_i),
    .notify_en    (notify_en_i),
    .bus_crash_en (bus_crash_en_i),
    .cur_task     (cur_task_i),
    .pipe_task    (pipe_task_i),
    .dirty        (dirty_i),
    .vpage        (vpage_i),
    .verdict      (mem_v)
  );

  assign sel_v = mem_only_w ? mem_v : pri_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      q_v    <= '0;
    end else begin
      done_o <= vld_i;
      if (vld_i) q_v <= sel_v;
    end
  end

  assign action_o = q_v.act;
  assign code_o   = q_v.code;
  assign parm_o   = q_v.parm;
endmodule

// File: rtl/fc_checker.sv
`timescale 1ns/1ps
module fc_checker
  import fc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              vld_i,
  input logic              mem_only_w,
  input logic              bus_par_i,
  input logic              addr_oob_i,
  input logic              st2a_err_i,
  input logic              st2b_err_i,
  input logic              bus_crash_en_i,
  input logic              done_o,
  input logic [2:0]        action_o,
  input logic [CODE_W-1:0] code_o,
  input logic [PARM_W-1:0] parm_o
);
  a_r1_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> done_o);

  a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> !done_o);

  a_r1_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> ($stable(action_o) && $stable(code_o) && $stable(parm_o)));

  a_r2_legal_action: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($countones(action_o) == 1));

  a_r2_crash_no_parm: assert property (@(posedge clk) disable iff (!rst_n)
    (action_o == ACT_CRASH) |-> (parm_o == '0));

  a_r2_notify_no_code: assert property (@(posedge clk) disable iff (!rst_n)
    (action_o == ACT_NOTIFY) |-> (code_o == '0));

  a_r6_buspar_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && mem_only_w && bus_par_i && !bus_crash_en_i) |=> (action_o == ACT_RESUME));

  a_r8_double_stage2: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && mem_only_w && !bus_par_i && !addr_oob_i && st2a_err_i && st2b_err_i)
      |=> (action_o == ACT_CRASH && code_o == CC_DOUBLE));
endmodule

bind fault_classifier fc_checker u_fc_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .vld_i          (vld_i),
  .mem_only_w     (mem_only_w),
  .bus_par_i      (bus_par_i),
  .addr_oob_i     (addr_oob_i),
  .st2a_err_i     (st2a_err_i),
  .st2b_err_i     (st2b_err_i),
  .bus_crash_en_i (bus_crash_en_i),
  .done_o         (done_o),
  .action_o       (action_o),
  .code_o         (code_o),
  .parm_o         (parm_o)
);

// File: tb/test_fault_classifier.sv
`timescale 1ns/1ps
module test_fault_classifier;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic stk = 0, csp = 0, rfp = 0, mer = 0;
  logic s2a = 0, s2b = 0, s1a = 0, s1b = 0;
  logic bpar = 0, oob = 0, nen = 0, bce = 0, dirty = 0;
  logic [3:0]  ctask = 0, ptask = 0;
  logic [13:0] vpage = 0;
  logic        done;
  logic [2:0]  action;
  logic [7:0]  code;
  logic [15:0] parm;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fault_classifier i_fault_classifier (
    .clk(clk), .rst_n(rst_n), .vld_i(vld),
    .stk_ovf_i(stk), .cstore_par_i(csp), .rfile_par_i(rfp), .mem_err_i(mer),
    .st2a_err_i(s2a), .st2b_err_i(s2b), .st1a_err_i(s1a), .st1b_err_i(s1b),
    .bus_par_i(bpar), .addr_oob_i(oob), .notify_en_i(nen), .bus_crash_en_i(bce),
    .cur_task_i(ctask), .pipe_task_i(ptask), .dirty_i(dirty), .vpage_i(vpage),
    .done_o(done), .action_o(action), .code_o(code), .parm_o(parm)
  );

  // expected {action, code, parm}; tag names the deciding requirement
  function automatic logic [26:0] expect_of(output string tag);
    logic [2:0] a; logic [7:0] c; logic [15:0] p;
    int prim;
    prim = {stk, csp, rfp, mer};
    a = 3'b001; c = 8'h00; p = 16'h0000;
    if (prim == 1) begin
      if (bpar) begin
        tag = "R6";
        if (bce) c = 8'h40 + {4'h0, ctask}; else a = 3'b010;
      end else if (oob) begin
        tag = "R7";
        if (nen) begin a = 3'b100; p = 16'hFFFF; end
        else c = 8'h50 + {4'h0, ctask};
      end else if (s2a && s2b) begin tag = "R8"; c = 8'h80; end
      else if (s2a || s2b)      begin tag = "R8"; c = 8'h70 + {4'h0, ptask}; end
      else if (s1a || s1b) begin
        if (nen && ptask == 0) begin
          tag = "R10"; a = 3'b100;
          p = dirty ? (16'h8000 | {2'b00, vpage}) : {2'b00, vpage};
        end else begin tag = "R9"; c = 8'h60 + {4'h0, ptask}; end
      end else begin tag = "R11"; c = 8'h81; end
    end else if (prim == 0) begin tag = "R3"; c = 8'h10 + {4'h0, ctask}; end
    else if (csp || rfp) begin tag = "R4"; c = 8'h20 + 8'(prim); end
    else begin
      tag = "R5";
      if (nen) begin a = 3'b100; p = 16'h4000; end else c = 8'h30;
    end
    return {a, c, p};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic strobe_and_check(input bit check_hold);
    string tag;
    logic [26:0] e;
    logic [26:0] got;
    @(negedge clk);
    vld = 1'b1;
    e = expect_of(tag);
    @(negedge clk);
    vld = 1'b0;
    got = {action, code, parm};
    check(done === 1'b1, "R1", "done after strobe", {31'b0, done}, 32'h1);
    check($countones(action) == 1, "R2", "one-hot action", {29'b0, action}, {29'b0, e[26:24]});
    check(got === e, tag, "verdict", {5'b0, got}, {5'b0, e});
    if (check_hold) begin
      @(negedge clk);
      check(done === 1'b0 && {action, code, parm} === e, "R1", "hold without strobe",
            {4'b0, done, got}, {5'b0, e});
    end
  endtask

  task automatic set_case(input logic [3:0] prim, input logic [5:0] mf,
                          input logic n, input logic b, input logic [3:0] ct,
                          input logic [3:0] pt, input logic d, input logic [13:0] pg);
    {stk, csp, rfp, mer} = prim;
    {bpar, oob, s2a, s2b, s1a, s1b} = mf;
    nen = n; bce = b; ctask = ct; ptask = pt; dirty = d; vpage = pg;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check(done === 1'b0 && action === 3'b000 && code === 8'h00 && parm === 16'h0000,
          "R1", "reset state", {4'b0, done, action, code, parm}, 32'h0);
    rst_n = 1'b1;

    // R3 breakpoint with task offset
    set_case(4'b0000, 6'b000000, 1, 0, 4'd9, 4'd0, 0, 14'h0); strobe_and_check(1);
    // R4 every parity combination
    for (int k = 0; k < 16; k++) begin
      if (k[2] || k[1]) begin
        set_case(4'(k), 6'b001111, 1, 1, 4'd3, 4'd5, 0, 14'h1); strobe_and_check(0);
      end
    end
    // R5 stack alone and stack with memory error, both enables
    set_case(4'b1000, 6'b0, 1, 0, 4'd0, 4'd0, 0, 14'h0); strobe_and_check(0);
    set_case(4'b1001, 6'b0, 0, 0, 4'd0, 4'd0, 0, 14'h0); strobe_and_check(1);
    // R6 bus parity ignored vs crash, with other memory flags present
    set_case(4'b0001, 6'b111111, 1, 0, 4'd7, 4'd2, 1, 14'h5); strobe_and_check(1);
    set_case(4'b0001, 6'b101000, 1, 1, 4'd7, 4'd2, 1, 14'h5); strobe_and_check(0);
    // R7 range notify and crash
    set_case(4'b0001, 6'b011111, 1, 0, 4'd4, 4'd0, 0, 14'h3FFF); strobe_and_check(0);
    set_case(4'b0001, 6'b010000, 0, 0, 4'd4, 4'd0, 0, 14'h3FFF); strobe_and_check(0);
    // R8 double and single second-stage, stage-one flags ignored
    set_case(4'b0001, 6'b001111, 1, 0, 4'd1, 4'd6, 0, 14'h2); strobe_and_check(0);
    set_case(4'b0001, 6'b000111, 1, 0, 4'd1, 4'd6, 0, 14'h2); strobe_and_check(0);
    set_case(4'b0001, 6'b001011, 1, 0, 4'd1, 4'd0, 0, 14'h2); strobe_and_check(0);
    // R9 stage-one crash: foreign pipe task, then notify disabled
    set_case(4'b0001, 6'b000010, 1, 0, 4'd0, 4'd12, 0, 14'h7); strobe_and_check(0);
    set_case(4'b0001, 6'b000001, 0, 0, 4'd0, 4'd0, 0, 14'h7); strobe_and_check(0);
    // R10 page fault vs write protect at the top page
    set_case(4'b0001, 6'b000010, 1, 0, 4'd3, 4'd0, 0, 14'h3FFF); strobe_and_check(0);
    set_case(4'b0001, 6'b000001, 1, 0, 4'd3, 4'd0, 1, 14'h3FFF); strobe_and_check(0);
    set_case(4'b0001, 6'b000011, 1, 0, 4'd3, 4'd0, 0, 14'h1234); strobe_and_check(0);
    // R11 no memory flag
    set_case(4'b0001, 6'b000000, 1, 1, 4'd3, 4'd3, 0, 14'h0); strobe_and_check(1);

    // constrained random, weighted toward the memory-only path
    for (int n = 0; n < 400; n++) begin
      r = $urandom;
      if (r[1:0] != 2'b00) {stk, csp, rfp, mer} = 4'b0001;
      else {stk, csp, rfp, mer} = r[31:28];
      bpar = (r[4:2] == 3'b000);
      oob  = (r[7:5] == 3'b000);
      {s2a, s2b, s1a, s1b} = r[8] ? 4'b0000 : r[12:9];
      ptask = r[13] ? 4'd0 : r[17:14];
      ctask = r[21:18];
      dirty = r[22];
      nen   = r[23] | r[24];
      bce   = r[25];
      vpage = 14'($urandom);
      strobe_and_check(r[26]);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule